// File: doc/BRIEF.md
# Port-Size Data Beat Sequencer

This block is the slave-side data-tenure controller of a 64-bit system bus that reaches devices whose data port is narrower than the bus. When a transfer starts, it captures the size code and the port width. It then steps through the port beats that the device has to move. Each cycle in which the device reports ready moves one beat and raises a per-beat valid strobe. On the last port beat of each 64-bit or 128-bit segment, the block also raises a termination acknowledge in the same cycle.

A watchdog watches the tenure. It counts consecutive cycles in which no beat moves. If the count reaches a programmable limit, the block raises a one-cycle error acknowledge, drops the tenure and goes back to idle without terminating it. Address generation, arbitration and the data path are handled elsewhere.

Top module: `beat_sequencer`

## Requirements
- R1: A `start` pulse while idle opens a tenure, and beats can move from the next cycle on. A `start` while a tenure is open is ignored and leaves the open tenure unchanged.
- R2: The `port` code selects the device port width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. The number of port beats per acknowledged segment is the segment width divided by the port width.
- R3: The `size` code 00 is a single 64-bit transfer ended by one acknowledge. 01 is a 128-bit transfer ended by one acknowledge. 10 and 11 are bursts of eight 64-bit segments with one acknowledge each, and the eighth acknowledge ends the tenure.
- R4: `beat_vld` is high in exactly those cycles of an open tenure in which `dev_rdy` is high. A low `dev_rdy` inserts a wait state and moves no beat.
- R5: `term_ack` is high only together with `beat_vld`, on the last port beat of each segment.
- R6: A 128-bit transfer to a 32-bit port shows three beats with `beat_vld` alone, then a fourth beat with both `beat_vld` and `term_ack`.
- R7: With a limit L other than 0, `err_ack` rises for one cycle on the L-th consecutive cycle of an open tenure without a beat. The tenure then closes with no `term_ack`, and `dev_rdy` has no effect afterwards. A beat restarts the count, so gaps of L-1 wait cycles never raise an error.
- R8: `err_ack` and `term_ack` are never high in the same cycle.
- R9: A limit of 0 turns the watchdog off, so any number of wait states is allowed.
- R10: While `rst_n` is low, all three outputs are low and no tenure is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a tenure when idle |
| size | input | 2 | Transfer size code, sampled at start |
| port | input | 2 | Device port width code, sampled at start |
| dev_rdy | input | 1 | Device ready for one port beat this cycle |
| tmo_limit | input | TMO_W | Watchdog limit in wait cycles, 0 disables |
| beat_vld | output | 1 | A port beat moves this cycle |
| term_ack | output | 1 | The current segment ends this cycle |
| err_ack | output | 1 | The tenure is aborted by the watchdog |

## Verification
A wrong beat or segment count shows up at the ports at the first acknowledge. The acknowledge either lands on the wrong beat, or the tenure keeps producing beats, or it stops producing them. The scoreboard compares every beat in order, so such an error is caught on the first mismatched beat. A stuck watchdog count shows as an error acknowledge during legal wait gaps, or as none after a stalled tenure. A failure to return to idle shows as strobes appearing when the device is ready after an abort or after the final acknowledge.

// File: rtl/beat_sequencer.sv
module beat_sequencer #(
  parameter int BUS_W      = 64,
  parameter int BURST_SEGS = 8,
  parameter int TMO_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       size,
  input  logic [1:0]       port,
  input  logic             dev_rdy,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             beat_vld,
  output logic             term_ack,
  output logic             err_ack
);
  localparam int LEN_W = $clog2(2*BUS_W/8) + 1;
  localparam int SEG_W = $clog2(BURST_SEGS) + 1;

  logic             busy, dbl_q, burst_q;
  logic [1:0]       port_q;
  logic [LEN_W-1:0] sub_cnt, seg_len;
  logic [SEG_W-1:0] seg_cnt, seg_total;
  logic [TMO_W-1:0] idle_cnt;
  logic             last_seg;

  assign seg_len   = LEN_W'((dbl_q ? 2*BUS_W : BUS_W) >> (3 + port_q));
  assign seg_total = burst_q ? SEG_W'(BURST_SEGS) : SEG_W'(1);
  assign last_seg  = (seg_cnt == seg_total - 1'b1);

  assign beat_vld = busy & dev_rdy;
  assign term_ack = beat_vld & (sub_cnt == seg_len - 1'b1);
  assign err_ack  = busy & ~dev_rdy & (tmo_limit != '0) & (idle_cnt == tmo_limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dbl_q    <= 1'b0;
      burst_q  <= 1'b0;
      port_q   <= '0;
      sub_cnt  <= '0;
      seg_cnt  <= '0;
      idle_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        port_q   <= port;
        dbl_q    <= (size == 2'b01);
        burst_q  <= size[1];
        sub_cnt  <= '0;
        seg_cnt  <= '0;
        idle_cnt <= '0;
      end
    end else if (err_ack) begin
      busy <= 1'b0;
    end else if (beat_vld) begin
      idle_cnt <= '0;
      if (term_ack) begin
        sub_cnt <= '0;
        if (last_seg) busy <= 1'b0;
        else          seg_cnt <= seg_cnt + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R1
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R4
  vld_in_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> (busy && dev_rdy));
  // R7
  err_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |=> !busy);
  // R8
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_ack && term_ack));
  // R9
  err_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |-> (tmo_limit != '0));
  // R5
  term_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !term_ack) |=> busy);
endmodule

// File: tb/test_beat_sequencer.sv
module test_beat_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [1:0]  port = 2'b00;
  logic        dev_rdy = 1'b0;
  logic [15:0] tmo_limit = 16'd0;
  logic        beat_vld, term_ack, err_ack;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];

  always #2 clk = ~clk;

  beat_sequencer i_beat_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .port(port),
    .dev_rdy(dev_rdy), .tmo_limit(tmo_limit),
    .beat_vld(beat_vld), .term_ack(term_ack), .err_ack(err_ack));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every event cycle is compared with the next expected item {vld,term,err}
  always @(negedge clk) begin
    if (rst_n && (beat_vld || err_ack || term_ack)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R7 unexpected event", {29'd0, beat_vld, term_ack, err_ack}, 32'd0);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check({beat_vld, term_ack, err_ack} == e, "R2/R3/R4/R5/R6/R7/R8 beat",
              {29'd0, beat_vld, term_ack, err_ack}, {29'd0, e});
      end
    end
  end

  // Driver: pushes the expected beat stream, then drives the tenure
  task automatic run(input logic [1:0] sz, input logic [1:0] pw, input int gap,
                     input int stop_after, input bit poke);
    int len, segs, total, nb;
    len   = ((sz == 2'b01) ? 128 : 64) >> (3 + pw);
    segs  = sz[1] ? 8 : 1;
    total = len * segs;
    nb    = (stop_after >= 0) ? stop_after : total;
    for (int b = 0; b < nb; b++)
      exp_q.push_back({1'b1, (b % len) == len - 1, 1'b0});
    if (stop_after >= 0) exp_q.push_back(3'b001);
    @(posedge clk); #1;
    start = 1'b1; size = sz; port = pw; dev_rdy = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int g = 0; g < gap; g++) begin
        dev_rdy = 1'b0;
        @(posedge clk); #1;
      end
      dev_rdy = 1'b1;
      start = poke && (b == 1);
      size  = poke ? 2'b10 : sz;
      port  = poke ? 2'b00 : pw;
      @(posedge clk); #1;
      start = 1'b0;
    end
    dev_rdy = 1'b0;
    if (stop_after >= 0) begin
      repeat (int'(tmo_limit) + 2) @(posedge clk);
      #1;
      // R7: after the abort, a ready device must not produce beats
      dev_rdy = 1'b1;
      repeat (6) @(posedge clk);
      #1;
      dev_rdy = 1'b0;
    end else begin
      // R3: after the final acknowledge, a ready device must not produce beats
      dev_rdy = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      dev_rdy = 1'b0;
    end
    repeat (2) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R3/R7 missing events", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    dev_rdy = 1'b1;
    start   = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs stay low while reset is held
    check({beat_vld, term_ack, err_ack} == 3'b000, "R10 reset outputs",
          {29'd0, beat_vld, term_ack, err_ack}, 0);
    @(posedge clk); #1;
    start = 1'b0; dev_rdy = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check({beat_vld, term_ack, err_ack} == 3'b000, "R10 idle after reset",
          {29'd0, beat_vld, term_ack, err_ack}, 0);

    tmo_limit = 16'd20;
    run(2'b00, 2'b11, 0, -1, 0);   // R2/R3: single to a 64-bit port
    run(2'b00, 2'b00, 0, -1, 0);   // R2: single to an 8-bit port
    run(2'b01, 2'b10, 0, -1, 0);   // R6: 128-bit to a 32-bit port
    run(2'b01, 2'b11, 0, -1, 0);   // R3: 128-bit to a 64-bit port
    run(2'b10, 2'b11, 0, -1, 0);   // R3: burst to a 64-bit port
    run(2'b11, 2'b01, 0, -1, 0);   // R3: burst, code 11, to a 16-bit port
    run(2'b10, 2'b10, 1, -1, 1);   // R1/R4: wait states and start while busy
    tmo_limit = 16'd3;
    run(2'b00, 2'b01, 2, -1, 0);   // R7: gaps of limit-1 never time out
    run(2'b00, 2'b00, 0, 3, 0);    // R7/R8: stall after three beats
    run(2'b10, 2'b11, 0, 0, 0);    // R7: stall before any beat
    tmo_limit = 16'd0;
    run(2'b00, 2'b10, 300, -1, 0); // R9: watchdog disabled

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule